// File: doc/BRIEF.md
# Static-Data Auto-Mute Controller

This controller watches a stereo stream of parallel audio samples and decides, for each channel, whether that channel's output should be silenced. A sample pair is presented on two data buses together with a one-cycle valid strobe. The controller looks for a long unbroken run of "silent" frames, meaning frames whose left and right words are each a constant pattern. When that run reaches a programmable length, it engages an automatic mute that covers both channels. The automatic mute clears as soon as a frame with real signal content arrives.

Two active-low manual hold inputs sit alongside the automatic path, one per channel. Each hold silences its own channel at once. Each channel's mute flag is the OR of the automatic state and that channel's hold. The automatic path has an active-low enable. While the enable is high, the automatic path contributes nothing and its run is discarded.

The control is a three-state machine. **OFF** means the automatic path is disabled. **WATCH** means frames are being counted. **MUTED** means the automatic mute is engaged. The transitions are as follows:
- *enable* moves OFF to WATCH when the enable input is low.
- *engage* moves WATCH to MUTED when the run is full and no breaking frame is present.
- *release* moves MUTED to WATCH on a breaking frame.
- *disable* moves any state to OFF when the enable input is high.

Top module: `static_automute`

## Requirements
- R1: While reset is asserted, and after its release, the automatic mute is disengaged and its run is empty. Each mute flag then equals the inverse of its channel's hold input.
- R2: A frame counts as static when each channel's SAMPLE_W-bit word is all zeros or all ones. The two channels may differ, for example left all zeros and right all ones.
- R3: Suppose the clock edge that accepts a valid frame brings the number of consecutive static frames to RUN_LEN. Both mute flags then rise after the next clock edge.
- R4: Cycles with the valid strobe low neither advance nor break the run, whatever the data buses carry.
- R5: A valid frame that is not static empties the run. If the automatic mute is engaged, it disengages at that clock edge.
- R6: While the enable input is high, the automatic path does not affect the mute flags, and this takes effect in the same cycle. At each such clock edge the run is emptied and the state returns to OFF, so a later re-enable has to build a fresh run of RUN_LEN frames.
- R7: A low hold input raises its own channel's mute flag in the same cycle. It does not affect the other channel.
- R8: The hold inputs do not affect the run or the automatic state. A run continues, and engages on schedule, while either hold is asserted.
- R9: The run length saturates at RUN_LEN. An arbitrarily long static stream keeps the automatic mute engaged and never wraps.
- R10: Suppose a non-static valid frame arrives in the cycle where the run has just become full. The automatic mute then does not engage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample pair valid strobe |
| smp_left | input | SAMPLE_W | Left channel word |
| smp_right | input | SAMPLE_W | Right channel word |
| automute_en_n | input | 1 | Automatic mute enable, active low |
| hold_left_n | input | 1 | Manual left mute, active low |
| hold_right_n | input | 1 | Manual right mute, active low |
| mute_left | output | 1 | Left channel muted |
| mute_right | output | 1 | Right channel muted |

## Verification
The engage decision and a breaking frame can land on the same clock edge. The bench provokes this by sending exactly RUN_LEN static frames followed at once by a non-static frame. It also sends RUN_LEN−1 static frames and then a break. The reference model judges both cases: the flags must stay low. Disabling the automatic path while it is engaged also meets a release in one cycle. For that case the bench requires the flags to drop combinationally in that cycle, and to stay down after a re-enable until a fresh run completes.

// File: rtl/amute_pkg.sv
package amute_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WATCH = 2'd1,
        ST_MUTED = 2'd2
    } amute_state_e;
endpackage

// File: rtl/amute_static_det.sv
module amute_static_det #(
    parameter int W = 20
) (
    input  logic [W-1:0] word,
    output logic         is_static
);
    logic all_ones;
    logic all_zeros;

    always_comb begin
        all_ones  = &word;
        all_zeros = ~(|word);
        is_static = all_ones | all_zeros;
    end
endmodule

// File: rtl/amute_run_ctr.sv
module amute_run_ctr #(
    parameter int LIMIT_VAL = 8192,
    parameter int CNT_W     = $clog2(LIMIT_VAL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic full
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LIMIT_VAL);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign full = (cnt_q == LIMIT);

    // R9: the run never passes its limit
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

    // R9: a full run stays full until cleared
    a_r9_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> full);
endmodule

// File: rtl/static_automute.sv
module static_automute
    import amute_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int RUN_LEN  = 8192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                automute_en_n,
    input  logic                hold_left_n,
    input  logic                hold_right_n,
    output logic                mute_left,
    output logic                mute_right
);
    localparam int NCH   = 2;
    localparam int CNT_W = $clog2(RUN_LEN + 1);

    logic [NCH-1:0][SAMPLE_W-1:0] words;
    logic [NCH-1:0]               ch_static;
    logic                         frame_static;
    logic                         brk;
    logic                         adv;
    logic                         ctr_clr;
    logic                         run_full;
    logic                         auto_on;
    amute_state_e                 state_q;
    amute_state_e                 state_d;

    assign words[0] = smp_left;
    assign words[1] = smp_right;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_det
            amute_static_det #(.W(SAMPLE_W)) u_det (
                .word      (words[g]),
                .is_static (ch_static[g])
            );
        end
    endgenerate

    always_comb begin
        frame_static = &ch_static;
        brk          = smp_valid && !frame_static;
        adv          = smp_valid && frame_static;
        ctr_clr      = automute_en_n || brk;
    end

    amute_run_ctr #(.LIMIT_VAL(RUN_LEN), .CNT_W(CNT_W)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .inc   (adv),
        .full  (run_full)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (automute_en_n) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_WATCH;
                ST_WATCH: if (run_full && !brk) state_d = ST_MUTED;
                ST_MUTED: if (brk) state_d = ST_WATCH;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        auto_on    = (state_q == ST_MUTED) && !automute_en_n;
        mute_left  = auto_on || !hold_left_n;
        mute_right = auto_on || !hold_right_n;
    end

    // R3: engaging only follows a full run
    a_r3_engage_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_MUTED) |-> $past(run_full));

    // R5: a breaking frame leaves the automatic mute disengaged
    a_r5_break_releases: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> (state_q != ST_MUTED));

    // R10: a breaking frame empties the run
    a_r10_break_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> !run_full);

    // R6: the disabled automatic path cannot raise a flag
    a_r6_disabled_left: assert property (@(posedge clk) disable iff (!rst_n)
        (automute_en_n && hold_left_n) |-> !mute_left);
    a_r6_disabled_right: assert property (@(posedge clk) disable iff (!rst_n)
        (automute_en_n && hold_right_n) |-> !mute_right);

    // R7: a manual hold always mutes its channel
    a_r7_hold_left: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_left_n |-> mute_left);
    a_r7_hold_right: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_right_n |-> mute_right);
endmodule

// File: tb/static_automute_bench.sv
module static_automute_bench;
    localparam int W = 20;
    localparam int N = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid = 1'b0;
    logic [W-1:0] left = '0;
    logic [W-1:0] right = '0;
    logic         en_n = 1'b0;
    logic         hl_n = 1'b1;
    logic         hr_n = 1'b1;
    logic         mute_left;
    logic         mute_right;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference model
    int m_run = 0;
    bit m_muted = 1'b0;

    static_automute #(.SAMPLE_W(W), .RUN_LEN(N)) u_static_automute (
        .clk           (clk),
        .rst_n         (rst_n),
        .smp_valid     (valid),
        .smp_left      (left),
        .smp_right     (right),
        .automute_en_n (en_n),
        .hold_left_n   (hl_n),
        .hold_right_n  (hr_n),
        .mute_left     (mute_left),
        .mute_right    (mute_right)
    );

    always #10 clk = ~clk;

    function automatic bit word_static(input logic [W-1:0] w);
        return (w == '0) || (w == '1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run   = 0;
            m_muted = 1'b0;
        end else if (en_n) begin
            m_run   = 0;
            m_muted = 1'b0;
        end else if (valid && !(word_static(left) && word_static(right))) begin
            m_run   = 0;
            m_muted = 1'b0;
        end else begin
            if (!m_muted && m_run >= N) m_muted = 1'b1;
            if (valid && m_run < N) m_run = m_run + 1;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            logic exp_l;
            logic exp_r;
            exp_l = (m_muted && !en_n) || !hl_n;
            exp_r = (m_muted && !en_n) || !hr_n;
            n_cmp++;
            if (mute_left !== exp_l) begin
                n_bad++;
                $display("FAIL %s mute_left actual=%b expected=%b t=%0t", cur_req, mute_left, exp_l, $time);
            end
            n_cmp++;
            if (mute_right !== exp_r) begin
                n_bad++;
                $display("FAIL %s mute_right actual=%b expected=%b t=%0t", cur_req, mute_right, exp_r, $time);
            end
        end
    end

    task automatic put(input logic v, input logic [W-1:0] l, input logic [W-1:0] r);
        @(posedge clk);
        #2;
        valid = v;
        left  = l;
        right = r;
    endtask

    task automatic frames(input int n, input logic [W-1:0] l, input logic [W-1:0] r);
        for (int i = 0; i < n; i++) put(1'b1, l, r);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(1'b0, 20'h5A5A5, 20'h0F0F0);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired in %s", cur_req);
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        idle(3);

        // R3: a run of zeros engages after N frames
        cur_req = "R3";
        frames(N, '0, '0);
        idle(6);                     // R4: idle cycles keep the mute
        // R5: non-static frame releases
        cur_req = "R5";
        frames(1, 20'h00010, '0);
        idle(3);

        // R2: mixed static patterns per channel
        cur_req = "R2";
        frames(N + 2, '0, '1);
        frames(N, '1, '1);
        cur_req = "R5";
        frames(1, '1, 20'h80000);
        idle(2);

        // R4: invalid cycles with noisy data do not break or advance
        cur_req = "R4";
        frames(30, '0, '0);
        idle(10);
        frames(N - 30, '0, '0);
        idle(4);
        frames(1, 20'h12345, '0);

        // R10: break in the engage cycle, and just before it
        cur_req = "R10";
        frames(N, '0, '0);
        frames(1, '0, 20'h00001);
        idle(3);
        frames(N - 1, '1, '0);
        frames(1, 20'h7FFFF, '0);
        idle(3);

        // R6: disable mid-run and while engaged
        cur_req = "R6";
        frames(40, '0, '0);
        @(posedge clk); #2 en_n = 1'b1; valid = 1'b0;
        idle(3);
        @(posedge clk); #2 en_n = 1'b0;
        frames(30, '0, '0);
        frames(N - 30 + 2, '0, '0);
        @(posedge clk); #2 en_n = 1'b1;
        frames(5, '0, '0);
        @(posedge clk); #2 en_n = 1'b0;
        frames(N + 2, '0, '0);
        frames(1, 20'h00100, 20'h00100);

        // R7: manual holds, one channel at a time
        cur_req = "R7";
        @(posedge clk); #2 hl_n = 1'b0;
        idle(3);
        @(posedge clk); #2 hl_n = 1'b1; hr_n = 1'b0;
        idle(3);
        @(posedge clk); #2 hr_n = 1'b1;

        // R8: holds toggled during a run do not disturb it
        cur_req = "R8";
        frames(10, '0, '0);
        @(posedge clk); #2 hl_n = 1'b0; hr_n = 1'b0;
        frames(30, '0, '0);
        @(posedge clk); #2 hl_n = 1'b1;
        frames(N - 40 + 3, '0, '0);
        @(posedge clk); #2 hr_n = 1'b1;
        idle(2);

        // R9: long static stream stays engaged
        cur_req = "R9";
        frames(5 * N, '1, '1);
        frames(1, 20'h00002, '1);
        idle(4);

        finish_run();
    end
endmodule